// File: doc/BRIEF.md
# Tiled Convolver Expansion Summing Stage

This block sits at the output of one tile of a large two-dimensional convolution window. That window is cut into partial windows, and each partial window is computed by its own device. The block adds the tile's local partial sum to the expansion stream that arrives from the neighbouring tile. It then presents the result on its expansion output, which feeds the next tile in the chain. The expansion stream first goes through a fixed 4-beat link delay. It then goes through an optional further 4-beat delay, which is needed when tiles are 8 pixels wide. Last comes an optional long delay that covers the latency of a whole stripe of rows. The first tile in a chain can instead force the expansion contribution to zero, so that it sends out only its own sum.

Both input streams share one valid/ready handshake. A beat is accepted on a clock edge where `s_valid` and `s_ready` are both high and reset is low. Only accepted beats advance the delay lines and the adder. The output is a single register stage. `s_ready` is high whenever that register is empty or is being drained in the same cycle (`m_ready` high). Back-pressure on the output therefore stops intake within the same cycle. Configuration pins are captured only while the synchronous reset is asserted. The same reset clears every delay line to zero.

Delays are counted in accepted beats. The expansion latency is N = 4 + 4·extra + D. Here D is 0 for stripe code 00, LINE_LEN·ROWS_A for 01, LINE_LEN·ROWS_B for 10 and LINE_LEN·ROWS_C for 11. By default the sum is W+1 bits wide. Setting SAT=1 gives a W-bit sum that saturates.

Top module: `xd_exp_stage`

## Requirements
- R1: While `rst` is high, the configuration pins are captured and `m_valid` goes low. After `rst` falls, `m_valid` is low and `s_ready` is high. All delay history reads as zero, so each of the first N outputs equals the local sum alone.
- R2: With the captured zero bit (`cfg_zero_exp`) set, every output equals the sign-extended local sample of its beat, whatever `s_exp` carries.
- R3: With extra bit 0 and stripe code 00, output k equals local[k] + exp[k-4].
- R4: With extra bit 1 and stripe code 00, output k equals local[k] + exp[k-8].
- R5: Stripe codes 01, 10 and 11 add LINE_LEN·ROWS_A, LINE_LEN·ROWS_B and LINE_LEN·ROWS_C beats to the expansion latency. This adds to the delay set by the extra bit.
- R6: While `m_valid` is high and `m_ready` is low, `s_ready` is low, and `m_valid` and `m_sum` hold steady. Cycles without an accepted beat do not advance any delay line.
- R7: Changes on the configuration pins while `rst` is low have no effect on the output.
- R8: With SAT=0, `m_sum` is the exact signed sum in W+1 bits, and it carries the full range from extreme inputs such as 127+127 and -128+-128.
- R9: An output becomes valid only in the cycle after an accepted input beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; captures configuration and clears delay lines |
| cfg_zero_exp | input | 1 | Force the expansion contribution to zero (first tile of a chain) |
| cfg_extra_delay | input | 1 | Add 4 beats of expansion delay (8-wide tiles) |
| cfg_stripe_sel | input | 2 | Stripe delay code: 00 none, 01/10/11 select ROWS_A/B/C rows |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_local | input | W | Local partial sum, signed |
| s_exp | input | W | Expansion input from the neighbour, signed |
| m_valid | output | 1 | Output sum valid |
| m_ready | input | 1 | Downstream accepts the output |
| m_sum | output | W+1 (W if SAT=1) | Expansion output, signed |

## Verification
The assertions assume that `m_ready` is a plain level the downstream may change on any cycle. They also assume the configuration pins are meaningful only while `rst` is high. The stimulus keeps to both of these. It moves `s_valid` and `m_ready` at the falling edge, with patterns that give both idle gaps and stalls that last several cycles. Right after each reset release it drives every configuration pin to the opposite of the captured value. Each of the sixteen configurations streams a fixed beat sequence. That sequence includes extreme values, and the run is long enough to pass through the largest delay that applies.

// File: rtl/xd_pkg.sv
package xd_pkg;

  localparam int LINK_STAGES  = 4;
  localparam int EXTRA_STAGES = 4;

  typedef struct packed {
    logic       zero_exp;
    logic       extra;
    logic [1:0] stripe;
  } xd_cfg_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/xd_shift_pipe.sv
module xd_shift_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[i] <= '0;
      end else if (adv) begin
        if (i == 0) stg[i] <= din;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/xd_stripe_buf.sv
module xd_stripe_buf #(
  parameter int W    = 8,
  parameter int MAXD = 128,
  localparam int AW  = (MAXD > 1) ? $clog2(MAXD) : 1,
  localparam int DW  = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] depth,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);

  logic [W-1:0]  mem [MAXD];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  always_comb begin
    int w_i;
    int d_i;
    int r_i;
    w_i = int'(wptr);
    d_i = int'(depth);
    if (w_i >= d_i) r_i = w_i - d_i;
    else            r_i = w_i + MAXD - d_i;
    rptr = AW'(r_i);
  end

  assign dout = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      for (int i = 0; i < MAXD; i++) mem[i] <= '0;
    end else if (adv) begin
      mem[wptr] <= din;
      if (wptr == AW'(MAXD - 1)) wptr <= '0;
      else                       wptr <= wptr + 1'b1;
    end
  end

endmodule

// File: rtl/xd_sum_unit.sv
module xd_sum_unit #(
  parameter int W   = 8,
  parameter int SAT = 0,
  localparam int OW = (SAT != 0) ? W : W + 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [OW-1:0] y
);

  logic signed [W:0] wide;
  assign wide = $signed({a[W-1], a}) + $signed({b[W-1], b});

  if (SAT != 0) begin : g_sat
    localparam logic signed [W:0] HI = $signed({2'b00, {(W-1){1'b1}}});
    localparam logic signed [W:0] LO = $signed({2'b11, {(W-1){1'b0}}});
    always_comb begin
      if (wide > HI)      y = HI[W-1:0];
      else if (wide < LO) y = LO[W-1:0];
      else                y = wide[W-1:0];
    end
  end else begin : g_wide
    assign y = wide;
  end

endmodule

// File: rtl/xd_exp_stage.sv
module xd_exp_stage #(
  parameter int W        = 8,
  parameter int LINE_LEN = 8,
  parameter int ROWS_A   = 4,
  parameter int ROWS_B   = 8,
  parameter int ROWS_C   = 16,
  parameter int SAT      = 0,
  localparam int OW      = (SAT != 0) ? W : W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_zero_exp,
  input  logic          cfg_extra_delay,
  input  logic [1:0]    cfg_stripe_sel,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [W-1:0]  s_local,
  input  logic [W-1:0]  s_exp,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_sum
);

  import xd_pkg::*;

  localparam int DEP_A = LINE_LEN * ROWS_A;
  localparam int DEP_B = LINE_LEN * ROWS_B;
  localparam int DEP_C = LINE_LEN * ROWS_C;
  localparam int MAXD  = max3(DEP_A, DEP_B, DEP_C);
  localparam int DW    = $clog2(MAXD + 1);

  xd_cfg_t cfg_q;
  logic    cfg_zero_q;
  logic    beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.zero_exp <= cfg_zero_exp;
      cfg_q.extra    <= cfg_extra_delay;
      cfg_q.stripe   <= cfg_stripe_sel;
    end
  end
  assign cfg_zero_q = cfg_q.zero_exp;

  assign s_ready = !rst && (!m_valid || m_ready);
  assign beat    = s_valid && s_ready;

  logic [W-1:0] link_out;
  logic [W-1:0] extra_out;
  logic [W-1:0] pre_stripe;
  logic [W-1:0] stripe_out;
  logic [W-1:0] exp_term;
  logic [DW-1:0] stripe_depth;

  xd_shift_pipe #(.W(W), .STAGES(LINK_STAGES)) u_link (
    .clk (clk), .rst (rst), .adv (beat), .din (s_exp), .dout (link_out)
  );

  xd_shift_pipe #(.W(W), .STAGES(EXTRA_STAGES)) u_extra (
    .clk (clk), .rst (rst), .adv (beat), .din (link_out), .dout (extra_out)
  );

  assign pre_stripe = cfg_q.extra ? extra_out : link_out;

  always_comb begin
    case (cfg_q.stripe)
      2'b01:   stripe_depth = DW'(DEP_A);
      2'b10:   stripe_depth = DW'(DEP_B);
      2'b11:   stripe_depth = DW'(DEP_C);
      default: stripe_depth = DW'(MAXD);
    endcase
  end

  xd_stripe_buf #(.W(W), .MAXD(MAXD)) u_stripe (
    .clk   (clk),
    .rst   (rst),
    .adv   (beat),
    .depth (stripe_depth),
    .din   (pre_stripe),
    .dout  (stripe_out)
  );

  always_comb begin
    if (cfg_q.zero_exp)          exp_term = '0;
    else if (cfg_q.stripe == '0) exp_term = pre_stripe;
    else                         exp_term = stripe_out;
  end

  logic [OW-1:0] sum_c;

  xd_sum_unit #(.W(W), .SAT(SAT)) u_sum (
    .a (s_local), .b (exp_term), .y (sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_sum   <= '0;
    end else if (beat) begin
      m_valid <= 1'b1;
      m_sum   <= sum_c;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/xd_exp_stage_chk.sv
module xd_exp_stage_chk #(
  parameter int W  = 8,
  parameter int OW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic [W-1:0]  s_local,
  input logic          m_valid,
  input logic          m_ready,
  input logic [OW-1:0] m_sum,
  input logic          zero_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !m_valid);

  a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_sum)));

  a_r6_backpressure: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  a_r2_zero_passes_local: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && zero_q) |=> ($signed(m_sum) == $signed($past(s_local))));

  a_r9_valid_from_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(s_valid && s_ready));

endmodule

bind xd_exp_stage xd_exp_stage_chk #(.W(W), .OW(OW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_local (s_local),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_sum   (m_sum),
  .zero_q  (cfg_zero_q)
);

// File: tb/xd_exp_stage_test.sv
module xd_exp_stage_test;

  localparam int W  = 8;
  localparam int LL = 2;
  localparam int OW = W + 1;
  localparam int NB = 90;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_zero_exp = 1'b0;
  logic          cfg_extra_delay = 1'b0;
  logic [1:0]    cfg_stripe_sel = 2'b00;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [W-1:0]  s_local = '0;
  logic [W-1:0]  s_exp = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [OW-1:0] m_sum;

  always #4 clk = ~clk;

  xd_exp_stage #(.W(W), .LINE_LEN(LL), .ROWS_A(4), .ROWS_B(8), .ROWS_C(16), .SAT(0)) uut (
    .clk (clk), .rst (rst),
    .cfg_zero_exp (cfg_zero_exp), .cfg_extra_delay (cfg_extra_delay),
    .cfg_stripe_sel (cfg_stripe_sel),
    .s_valid (s_valid), .s_ready (s_ready), .s_local (s_local), .s_exp (s_exp),
    .m_valid (m_valid), .m_ready (m_ready), .m_sum (m_sum)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int loc_a [NB];
  int exp_a [NB];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int gen(input int k, input int salt);
    int v;
    if (k % 7 == 3)       v = 127;
    else if (k % 11 == 5) v = -128;
    else                  v = ((k * 37 + salt * 53 + 11) % 256) - 128;
    return v;
  endfunction

  task automatic run_cfg(input bit z, input bit e, input int sel);
    int n_lat, nin, nout, cyc, held;
    bit hold_chk;
    string rq;
    n_lat = 4 + 4 * e + ((sel == 1) ? LL * 4 : (sel == 2) ? LL * 8 : (sel == 3) ? LL * 16 : 0);
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b0;
    cfg_zero_exp = z; cfg_extra_delay = e; cfg_stripe_sel = 2'(sel);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cfg_zero_exp = ~z; cfg_extra_delay = ~e; cfg_stripe_sel = ~2'(sel);
    #1;
    check(m_valid == 1'b0 && s_ready == 1'b1, "R1 reset state", int'(m_valid), 0);
    nin = 0; nout = 0; cyc = 0; hold_chk = 1'b0; held = 0;
    while (nout < NB && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      m_ready = ((cyc % 4) != 1) && ((cyc % 13) < 10);
      s_valid = (nin < NB) && (((cyc * 3 + sel) % 5) != 0);
      s_local = W'(gen(nin, 1 + sel));
      s_exp   = W'(gen(nin, 7 + 2 * int'(z) + int'(e)));
      #1;
      if (hold_chk)
        check(m_valid && int'($signed(m_sum)) == held, "R6 held output",
              int'($signed(m_sum)), held);
      if (s_valid && s_ready) begin
        loc_a[nin] = gen(nin, 1 + sel);
        exp_a[nin] = gen(nin, 7 + 2 * int'(z) + int'(e));
        nin++;
      end
      if (m_valid && m_ready) begin
        int expv;
        if (z)                expv = loc_a[nout];
        else if (nout < n_lat) expv = loc_a[nout];
        else                  expv = loc_a[nout] + exp_a[nout - n_lat];
        if (z)                  rq = "R2 zeroed expansion (R7 cfg held)";
        else if (nout < n_lat)  rq = "R1 flushed history";
        else if (expv > 127 || expv < -128) rq = "R8 full-width sum";
        else if (sel != 0)      rq = "R5 stripe delay";
        else if (e)             rq = "R4 extra delay";
        else                    rq = "R3 link delay";
        check(int'($signed(m_sum)) == expv, rq, int'($signed(m_sum)), expv);
        nout++;
      end
      hold_chk = m_valid && !m_ready;
      held = int'($signed(m_sum));
    end
    check(nout == NB, "R9 output count", nout, NB);
  endtask

  initial begin
    for (int z = 0; z < 2; z++)
      for (int e = 0; e < 2; e++)
        for (int sel = 0; sel < 4; sel++)
          run_cfg(z[0], e[0], sel);
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule